// File: doc/BRIEF.md
# Serial Control-Word Receiver with Frame-Length Qualification

This block is the serial front end of a 16-bit control register that may sit in a chain of serial devices sharing one chip select. While chip select is low, command bits arrive on the data input and are shifted into a 16-bit register. At the same time, the register's oldest bit leaves on the data output. At the start of a frame, the register is loaded with a parallel diagnostic-status word, so the host first reads back status and then sees the bits it sent, delayed by sixteen clocks. This is what a downstream device in a chain needs.

When chip select returns high, the received word is written to the parallel control output only if the number of serial clocks in the frame was a nonzero multiple of eight and at least sixteen. Because any such multiple is accepted, the block can be placed in chains that mix 8-bit and 16-bit devices. After a longer frame, the control register holds the last sixteen bits received. An accepted frame gives a one-cycle commit pulse. A rejected frame leaves the control register as it was and gives a one-cycle error pulse.

All serial pins are oversampled by the system clock through two-flop synchronisers. The serial clock must run at no more than a quarter of the system clock rate, and it must be low whenever chip select changes.

Top module: `spi_frame_slave`

## Requirements
- R1: After reset, `ctrl_o` is all zeros, and `commit_o`, `frame_err_o` and `so_oe` are low.
- R2: `so_oe` is low while chip select is high. It goes high after chip select falls and drops again when chip select rises.
- R3: When chip select falls, `status_i` is captured. Its bit 15 appears on `so` before the first serial clock edge. Later changes of `status_i` during the frame have no effect on `so`.
- R4: `si` is sampled on the serial clock falling edge, most significant bit first. `so` moves to the next bit only after a serial clock rising edge, so the host reads status bits 15 down to 0 in order.
- R5: The bit leaving on `so` is always the oldest bit held. From clock 17 onward, `so` repeats the bits received on `si`, sixteen clocks late.
- R6: A frame whose serial clock count is a multiple of eight and at least 16 is accepted. `ctrl_o` then becomes the last 16 bits received, with the last bit received in bit 0.
- R7: A frame with fewer than 16 clocks is rejected, including a count of 8 and a count of 0.
- R8: A frame whose clock count is not a multiple of eight is rejected.
- R9: The clock counter saturates at its all-ones value (255 by default) and never wraps. A 272-clock frame is therefore rejected.
- R10: `commit_o` and `frame_err_o` are single-cycle pulses and are never high together. A rejected frame leaves `ctrl_o` unchanged.
- R11: `commit_o`, `frame_err_o` and the new `ctrl_o` become visible after the third system clock rising edge that follows the chip select rise on the pin, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| status_i | input | 16 | Diagnostic-status word, loaded when a frame starts |
| so | output | 1 | Serial data out; meaningful only while `so_oe` is high |
| so_oe | output | 1 | Output enable for the tri-state pad driving `so` |
| ctrl_o | output | 16 | Committed control word |
| commit_o | output | 1 | One-cycle pulse when a frame is accepted |
| frame_err_o | output | 1 | One-cycle pulse when a frame is rejected |

## Verification
Every pin change takes three system clocks to reach an output: two synchroniser stages, then the register that acts on the detected edge. A chip select rise therefore shows up on `commit_o`, `frame_err_o` and `ctrl_o` after the third rising edge. The bench drives pins on falling edges. It samples once after the second rising edge to confirm nothing has changed yet, then again after the third to find the pulse, and once more a cycle later to confirm the pulse has ended. Each serial clock phase lasts four system clocks, and `so` is read just before each falling serial edge, after the three-cycle delay from the preceding rising edge has passed.

// File: rtl/spi_frame_slave.sv
`timescale 1ns/1ps
module spi_frame_slave #(
  parameter int WORD_W   = 16,
  parameter int GROUP    = 8,
  parameter int MIN_CLKS = 16,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              si,
  input  logic [WORD_W-1:0] status_i,
  output logic              so,
  output logic              so_oe,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              commit_o,
  output logic              frame_err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_CLKS);
  localparam logic [CNT_W-1:0] CNT_GRP = CNT_W'(GROUP);

  logic [1:0] cs_sy, sck_sy, si_sy;
  logic       cs_d, sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= 2'b11;
      sck_sy <= 2'b00;
      si_sy  <= 2'b00;
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_sy  <= {cs_sy[0], cs_n};
      sck_sy <= {sck_sy[0], sclk};
      si_sy  <= {si_sy[0], si};
      cs_d   <= cs_sy[1];
      sck_d  <= sck_sy[1];
    end
  end

  logic              active;
  logic [WORD_W-1:0] shreg;
  logic              out_q;
  logic [CNT_W-1:0]  cnt;

  wire cs_fall  = cs_d & ~cs_sy[1];
  wire cs_rise  = ~cs_d & cs_sy[1];
  wire sck_rise = active & ~sck_d & sck_sy[1];
  wire sck_fall = active & sck_d & ~sck_sy[1];
  wire len_ok   = ((cnt % CNT_GRP) == '0) && (cnt >= CNT_MIN) && (cnt != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      shreg       <= '0;
      out_q       <= 1'b0;
      cnt         <= '0;
      ctrl_o      <= '0;
      commit_o    <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      commit_o    <= 1'b0;
      frame_err_o <= 1'b0;
      if (cs_fall) begin
        active <= 1'b1;
        shreg  <= status_i;
        out_q  <= status_i[WORD_W-1];
        cnt    <= '0;
      end else if (cs_rise) begin
        active <= 1'b0;
        if (active && len_ok) begin
          ctrl_o   <= shreg;
          commit_o <= 1'b1;
        end else if (active) begin
          frame_err_o <= 1'b1;
        end
      end else begin
        if (sck_fall) begin
          shreg <= {shreg[WORD_W-2:0], si_sy[1]};
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end
        if (sck_rise) out_q <= shreg[WORD_W-1];
      end
    end
  end

  assign so    = out_q;
  assign so_oe = active;

  p_pulses_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_o && frame_err_o));
  p_commit_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
  p_err_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o);
  p_ctrl_only_on_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> commit_o);
  p_oe_off_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o || frame_err_o) |-> !so_oe);
  p_so_moves_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> $past(sck_rise || cs_fall));
  p_cnt_never_wraps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && $past(cnt) != '0) |-> $past(cs_fall));
endmodule

// File: tb/sim_spi_frame_slave.sv
`timescale 1ns/1ps
module sim_spi_frame_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
  logic [15:0] status_i = '0;
  logic        so, so_oe, commit_o, frame_err_o;
  logic [15:0] ctrl_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] exp_ctrl = '0;

  always #2.5 clk = ~clk;

  spi_frame_slave u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
    .status_i(status_i), .so(so), .so_oe(so_oe), .ctrl_o(ctrl_o),
    .commit_o(commit_o), .frame_err_o(frame_err_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // bits are sent MSB first: bit i of the frame is v[n-1-i]
  task automatic frame_case(input string req, input int n, input logic [299:0] v,
                            input logic [15:0] st, input bit accept);
    int so_bad;
    logic expb;
    so_bad = 0;
    @(negedge clk);
    status_i = st;
    cs_n = 1'b0;
    wait_neg(6);
    chk("R2 so_oe after cs fall", so_oe, 1);
    chk("R3 status msb before first edge", so, st[15]);
    status_i = ~st;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      si = v[n-1-i];
      wait_neg(4);
      expb = (i < 16) ? st[15-i] : v[n-1-(i-16)];
      if (so !== expb) so_bad++;
      sclk = 1'b0;
      wait_neg(4);
    end
    if (n > 0) chk({req, " R3 R4 R5 so stream mismatches"}, so_bad, 0);
    cs_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R11 no result before third edge", {commit_o, frame_err_o}, 2'b00);
    @(posedge clk);
    @(negedge clk);
    if (accept) exp_ctrl = v[15:0];
    chk({req, " R6 R7 R8 commit"}, commit_o, accept);
    chk({req, " R7 R8 frame error"}, frame_err_o, !accept);
    chk({req, " R6 R10 ctrl value"}, ctrl_o, exp_ctrl);
    chk("R2 so_oe low after cs rise", so_oe, 0);
    @(negedge clk);
    chk("R10 pulses last one cycle", {commit_o, frame_err_o}, 2'b00);
    wait_neg(4);
  endtask

  task automatic t_reset();
    chk("R1 ctrl reset", ctrl_o, 16'h0);
    chk("R1 pulses reset", {commit_o, frame_err_o}, 2'b00);
    chk("R1 R2 so_oe reset", so_oe, 0);
  endtask

  task automatic t_basic16();
    frame_case("R6 16clk", 16, 300'h0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_A5C3, 16'h9E37, 1);
  endtask

  task automatic t_short8();
    frame_case("R7 8clk", 8, 300'hFF, 16'h1234, 0);
  endtask

  task automatic t_zero();
    frame_case("R7 0clk", 0, '0, 16'hC001, 0);
  endtask

  task automatic t_odd17();
    frame_case("R8 17clk", 17, 300'h1_7E81, 16'h0F0F, 0);
  endtask

  task automatic t_len24();
    frame_case("R6 24clk", 24, 300'hB1_6D29, 16'h5AA5, 1);
  endtask

  task automatic t_daisy32();
    frame_case("R5 32clk", 32, 300'hDEAD_4C1F, 16'h8001, 1);
  endtask

  task automatic t_saturate();
    logic [299:0] v;
    v = '0;
    for (int i = 0; i < 272; i++) v[i] = ((i % 3) == 0) ^ ((i % 7) == 2);
    frame_case("R9 272clk", 272, v, 16'h3C96, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_neg(4);
    rst_n = 1'b1;
    wait_neg(4);
    t_reset();
    t_basic16();
    t_short8();
    t_zero();
    t_odd17();
    t_len24();
    t_daisy32();
    t_saturate();
    t_basic16();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule